// File: doc/BRIEF.md
# Exception Return Integrity Checker

This block judges whether an exception return request in a small microcontroller-class core may go ahead. In the first phase it receives the 32-bit return code that was branched to, together with the number of the exception being left and the outcome of retiring that exception in the interrupt controller. From these it either picks the unstacking target or calls for a usage fault. The unstacking target is handler mode, or thread mode on the main or the process stack. A usage fault is taken on the current frame and sets the invalid-PC status bit.

In the second phase, after the core has popped the saved registers, the block receives the restored status word. It compares the exception field of that word with the mode that the first phase requested. A mismatch raises the same usage fault, except that a fresh frame must be pushed before the fault is entered. The second phase also reports whether the alignment padding must be removed from the stack pointer.

Each phase is started by a single-cycle strobe. Its results are registered and valid in the cycle after the strobe, for exactly one cycle. Register popping, memory access and fault vectoring belong to the surrounding core.

Top module: `exc_return_check`

## Requirements
- R1: A phase-one strobe gives a one-cycle `p1_valid` on the next cycle. Return-code low nibble 1 sets `to_handler`. Nibble 9 selects thread mode on the main stack (`to_handler`=0, `use_psp`=0). Nibble 13 selects thread mode on the process stack (`use_psp`=1).
- R2: Any low-nibble value other than 1, 9 or 13 sets `p1_fault`.
- R3: The retire status is 2 bits: 00 means not active, 01 means still nested, 10 means back to base, and 11 is reserved. Status 00 or 11 sets `p1_fault`.
- R4: A thread-mode return (nibble 9 or 13) with status 01 faults when `nest_thread_en` is 0 and does not fault when it is 1. A handler return with status 01 does not fault.
- R5: If any of return-code bits 27..5 is zero, `unpred_warn` is set with `p1_valid`. This warning never changes `p1_fault`.
- R6: On a phase-one fault, `invpc_set` and `pend_usage` are 1 and `new_frame` is 0. `fault_retval` carries the return code with bits 31..28 forced to ones. Without a fault, `invpc_set`, `pend_usage` and `fault_retval` are 0.
- R7: In phase two, the exception field (status-word bits 8..0) is checked against the mode requested by the last phase one. A zero field after a handler request, or a nonzero field after a thread request, sets `p2_fault`, `invpc_set`, `pend_usage` and `new_frame`. `fault_retval` is then the latched return code with bits 31..28 set.
- R8: `clr_fmask` is set with `p1_valid` unless the exception number being left is 2, the non-maskable interrupt.
- R9: `sp_align_fix` is set with `p2_valid` exactly when bit 9 of the restored status word is 1.
- R10: During and right after a synchronous reset, all outputs are 0.
- R11: If both strobes arrive in the same cycle, phase one is served and the phase-two strobe is ignored: `p2_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p1_start | input | 1 | Phase-one strobe |
| ret_code | input | 32 | Return code that was branched to |
| cur_exc | input | 9 | Number of the exception being left |
| retire_st | input | 2 | Retire outcome (00 inactive, 01 nested, 10 base, 11 reserved) |
| nest_thread_en | input | 1 | Allow a thread-mode return while nested |
| p2_start | input | 1 | Phase-two strobe |
| restored_psr | input | 32 | Status word popped from the stack |
| p1_valid | output | 1 | Phase-one result valid |
| p1_fault | output | 1 | Phase-one integrity failure |
| to_handler | output | 1 | Unstack into handler mode |
| use_psp | output | 1 | Unstack from the process stack |
| unpred_warn | output | 1 | Return-code high bits not all ones |
| clr_fmask | output | 1 | Clear the fault-mask bit |
| p2_valid | output | 1 | Phase-two result valid |
| p2_fault | output | 1 | Mode mismatch after unstacking |
| sp_align_fix | output | 1 | Add 4 to the stack pointer |
| invpc_set | output | 1 | Set the invalid-PC status bit |
| pend_usage | output | 1 | Pend the usage fault |
| new_frame | output | 1 | Push a new frame before fault entry |
| fault_retval | output | 32 | Return value handed to fault entry |

## Verification
Three phase-one outcomes can fall in the same result cycle: the unpredictable-value warning, the fault-mask clear and an integrity fault. The table includes return codes whose high bits contain zeros and whose low nibble is also illegal. It also includes a return with a clean code but zero high bits. For each row the bench checks that the warning appears in both cases and that the fault flag follows only the nibble and the retire status. The two phase strobes are also raised together, and the bench checks that only the phase-one result is produced.

// File: rtl/excret_pkg.sv
package excret_pkg;
  typedef enum logic [1:0] {
    RS_INACTIVE = 2'b00,
    RS_NESTED   = 2'b01,
    RS_BASE     = 2'b10,
    RS_RSVD     = 2'b11
  } retire_e;

  localparam logic [3:0] CODE_HANDLER = 4'd1;
  localparam logic [3:0] CODE_THR_MSP = 4'd9;
  localparam logic [3:0] CODE_THR_PSP = 4'd13;

  typedef struct packed {
    logic fault;
    logic to_handler;
    logic use_psp;
    logic warn;
    logic clr_fmask;
  } p1_res_t;
endpackage

// File: rtl/excret_decode.sv
module excret_decode
  import excret_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EXC_W   = 9,
  parameter int NMI_NUM = 2,
  parameter int HI_LSB  = 5,
  parameter int HI_MSB  = 27
) (
  input  logic [DATA_W-1:0] ret_code,
  input  logic [EXC_W-1:0]  cur_exc,
  input  retire_e           status,
  input  logic              nest_en,
  output p1_res_t           res
);
  localparam int HI_W = HI_MSB - HI_LSB + 1;

  logic [3:0] nib;
  logic       code_ok, is_thread, active_ok, nest_bad;

  always_comb begin
    nib       = ret_code[3:0];
    code_ok   = (nib == CODE_HANDLER) || (nib == CODE_THR_MSP) || (nib == CODE_THR_PSP);
    is_thread = (nib == CODE_THR_MSP) || (nib == CODE_THR_PSP);
    active_ok = (status == RS_NESTED) || (status == RS_BASE);
    nest_bad  = is_thread && (status == RS_NESTED) && !nest_en;

    res.fault      = !code_ok || !active_ok || nest_bad;
    res.to_handler = (nib == CODE_HANDLER);
    res.use_psp    = (nib == CODE_THR_PSP);
    res.warn       = (ret_code[HI_MSB:HI_LSB] != {HI_W{1'b1}});
    res.clr_fmask  = (cur_exc != EXC_W'(NMI_NUM));
  end
endmodule

// File: rtl/excret_mode_check.sv
module excret_mode_check #(
  parameter int PSR_W     = 32,
  parameter int EXC_W     = 9,
  parameter int ALIGN_BIT = 9
) (
  input  logic             req_handler,
  input  logic [PSR_W-1:0] psr,
  output logic             mismatch,
  output logic             align_fix
);
  logic field_zero;

  always_comb begin
    field_zero = (psr[EXC_W-1:0] == '0);
    mismatch   = req_handler ? field_zero : !field_zero;
    align_fix  = psr[ALIGN_BIT];
  end
endmodule

// File: rtl/excret_fault_frame.sv
module excret_fault_frame #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] retval
);
  always_comb retval = {{TAG_W{1'b1}}, src[DATA_W-TAG_W-1:0]};
endmodule

// File: rtl/exc_return_check.sv
module exc_return_check
  import excret_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int EXC_W     = 9,
  parameter int NMI_NUM   = 2,
  parameter int ALIGN_BIT = 9,
  parameter int TAG_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p1_start,
  input  logic [DATA_W-1:0] ret_code,
  input  logic [EXC_W-1:0]  cur_exc,
  input  logic [1:0]        retire_st,
  input  logic              nest_thread_en,
  input  logic              p2_start,
  input  logic [DATA_W-1:0] restored_psr,
  output logic              p1_valid,
  output logic              p1_fault,
  output logic              to_handler,
  output logic              use_psp,
  output logic              unpred_warn,
  output logic              clr_fmask,
  output logic              p2_valid,
  output logic              p2_fault,
  output logic              sp_align_fix,
  output logic              invpc_set,
  output logic              pend_usage,
  output logic              new_frame,
  output logic [DATA_W-1:0] fault_retval
);
  localparam int HI_MSB = DATA_W - TAG_W - 1;

  p1_res_t           dec;
  logic              mis, align;
  logic              req_handler_q;
  logic [DATA_W-1:0] ret_q, frame_src, frame_val;

  excret_decode #(
    .DATA_W(DATA_W), .EXC_W(EXC_W), .NMI_NUM(NMI_NUM), .HI_LSB(5), .HI_MSB(HI_MSB)
  ) u_dec (
    .ret_code(ret_code), .cur_exc(cur_exc), .status(retire_e'(retire_st)),
    .nest_en(nest_thread_en), .res(dec)
  );

  excret_mode_check #(
    .PSR_W(DATA_W), .EXC_W(EXC_W), .ALIGN_BIT(ALIGN_BIT)
  ) u_mode (
    .req_handler(req_handler_q), .psr(restored_psr), .mismatch(mis), .align_fix(align)
  );

  assign frame_src = p1_start ? ret_code : ret_q;

  excret_fault_frame #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_frame (
    .src(frame_src), .retval(frame_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_handler_q <= 1'b0;
      ret_q         <= '0;
    end else if (p1_start) begin
      req_handler_q <= dec.to_handler;
      ret_q         <= ret_code;
    end
  end

  always_ff @(posedge clk) begin
    p1_valid     <= 1'b0;
    p1_fault     <= 1'b0;
    to_handler   <= 1'b0;
    use_psp      <= 1'b0;
    unpred_warn  <= 1'b0;
    clr_fmask    <= 1'b0;
    p2_valid     <= 1'b0;
    p2_fault     <= 1'b0;
    sp_align_fix <= 1'b0;
    invpc_set    <= 1'b0;
    pend_usage   <= 1'b0;
    new_frame    <= 1'b0;
    fault_retval <= '0;
    if (!rst) begin
      if (p1_start) begin
        p1_valid    <= 1'b1;
        p1_fault    <= dec.fault;
        to_handler  <= dec.to_handler;
        use_psp     <= dec.use_psp;
        unpred_warn <= dec.warn;
        clr_fmask   <= dec.clr_fmask;
        if (dec.fault) begin
          invpc_set    <= 1'b1;
          pend_usage   <= 1'b1;
          fault_retval <= frame_val;
        end
      end else if (p2_start) begin
        p2_valid     <= 1'b1;
        p2_fault     <= mis;
        sp_align_fix <= align;
        if (mis) begin
          invpc_set    <= 1'b1;
          pend_usage   <= 1'b1;
          new_frame    <= 1'b1;
          fault_retval <= frame_val;
        end
      end
    end
  end

  // R1
  p1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    p1_valid |-> $past(p1_start));
  // R6
  p1_fault_frame_chk: assert property (@(posedge clk) disable iff (rst)
    p1_fault |-> (invpc_set && pend_usage && !new_frame && fault_retval[DATA_W-1 -: TAG_W] == '1));
  // R7
  p2_fault_frame_chk: assert property (@(posedge clk) disable iff (rst)
    p2_fault |-> (new_frame && invpc_set && pend_usage && p2_valid));
  // R5
  warn_phase_chk: assert property (@(posedge clk) disable iff (rst)
    unpred_warn |-> p1_valid);
  // R8
  fmask_phase_chk: assert property (@(posedge clk) disable iff (rst)
    clr_fmask |-> p1_valid);
  // R11
  p2_excl_chk: assert property (@(posedge clk) disable iff (rst)
    p2_valid |-> (!$past(p1_start) && !p1_valid));
  // R9
  align_phase_chk: assert property (@(posedge clk) disable iff (rst)
    sp_align_fix |-> p2_valid);
endmodule

// File: tb/tb_exc_return_check.sv
module tb_exc_return_check;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        p1_start = 1'b0, p2_start = 1'b0, nest_thread_en = 1'b0;
  logic [31:0] ret_code = '0, restored_psr = '0;
  logic [8:0]  cur_exc = '0;
  logic [1:0]  retire_st = '0;
  logic        p1_valid, p1_fault, to_handler, use_psp, unpred_warn, clr_fmask;
  logic        p2_valid, p2_fault, sp_align_fix, invpc_set, pend_usage, new_frame;
  logic [31:0] fault_retval;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_return_check dut (
    .clk(clk), .rst(rst), .p1_start(p1_start), .ret_code(ret_code), .cur_exc(cur_exc),
    .retire_st(retire_st), .nest_thread_en(nest_thread_en), .p2_start(p2_start),
    .restored_psr(restored_psr), .p1_valid(p1_valid), .p1_fault(p1_fault),
    .to_handler(to_handler), .use_psp(use_psp), .unpred_warn(unpred_warn),
    .clr_fmask(clr_fmask), .p2_valid(p2_valid), .p2_fault(p2_fault),
    .sp_align_fix(sp_align_fix), .invpc_set(invpc_set), .pend_usage(pend_usage),
    .new_frame(new_frame), .fault_retval(fault_retval)
  );

  typedef struct packed {
    logic [31:0] ret;
    logic [8:0]  exc;
    logic [1:0]  st;
    logic        en;
    logic        fault;
    logic        hnd;
    logic        psp;
    logic        warn;
    logic        clr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'hFFFF_FFF1, 9'd3, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFF9, 9'd3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFFD, 9'd5, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'hFFFF_FFF9, 9'd7, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFFD, 9'd7, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'hFFFF_FFF1, 9'd7, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFF5, 9'd4, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFF1, 9'd4, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFF1, 9'd4, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hF000_0001, 9'd6, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{32'hFFFF_FFF9, 9'd2, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h0000_0003, 9'd2, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_p1(input logic [31:0] r, input logic [8:0] e, input logic [1:0] s,
                        input logic en);
    @(negedge clk);
    ret_code = r; cur_exc = e; retire_st = s; nest_thread_en = en; p1_start = 1'b1;
    @(negedge clk);
    p1_start = 1'b0;
  endtask

  task automatic run_p2(input logic [31:0] psr);
    @(negedge clk);
    restored_psr = psr; p2_start = 1'b1;
    @(negedge clk);
    p2_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 p1_valid", {31'b0, p1_valid}, 32'd0);
    check("R10 invpc", {31'b0, invpc_set}, 32'd0);
    check("R10 retval", fault_retval, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_p1(TBL[i].ret, TBL[i].exc, TBL[i].st, TBL[i].en);
      check("R1 p1_valid", {31'b0, p1_valid}, 32'd1);
      check("R2 R3 R4 p1_fault", {31'b0, p1_fault}, {31'b0, TBL[i].fault});
      check("R5 unpred_warn", {31'b0, unpred_warn}, {31'b0, TBL[i].warn});
      check("R8 clr_fmask", {31'b0, clr_fmask}, {31'b0, TBL[i].clr});
      check("R6 invpc", {31'b0, invpc_set}, {31'b0, TBL[i].fault});
      check("R6 pend", {31'b0, pend_usage}, {31'b0, TBL[i].fault});
      check("R6 new_frame", {31'b0, new_frame}, 32'd0);
      check("R6 retval", fault_retval, TBL[i].fault ? (TBL[i].ret | 32'hF000_0000) : 32'd0);
      if (!TBL[i].fault) begin
        check("R1 to_handler", {31'b0, to_handler}, {31'b0, TBL[i].hnd});
        check("R1 use_psp", {31'b0, use_psp}, {31'b0, TBL[i].psp});
      end
      @(negedge clk);
      check("R1 pulse", {31'b0, p1_valid}, 32'd0);
    end

    // R7 handler requested, restored field zero -> fault with new frame
    run_p1(32'hFFFF_FFF1, 9'd3, 2'b10, 1'b0);
    run_p2(32'h0000_0000);
    check("R7 p2_valid", {31'b0, p2_valid}, 32'd1);
    check("R7 p2_fault", {31'b0, p2_fault}, 32'd1);
    check("R7 new_frame", {31'b0, new_frame}, 32'd1);
    check("R7 invpc", {31'b0, invpc_set}, 32'd1);
    check("R7 retval", fault_retval, 32'hFFFF_FFF1);
    // R7 handler requested, nonzero field, align bit set
    run_p2(32'h0000_0203);
    check("R7 no fault", {31'b0, p2_fault}, 32'd0);
    check("R7 no pend", {31'b0, pend_usage}, 32'd0);
    check("R9 align", {31'b0, sp_align_fix}, 32'd1);
    // R7 thread requested, nonzero field -> fault
    run_p1(32'h7FFF_FFF9, 9'd3, 2'b10, 1'b0);
    run_p2(32'h0000_0010);
    check("R7 thread mismatch", {31'b0, p2_fault}, 32'd1);
    check("R7 thread retval", fault_retval, 32'hFFFF_FFF9);
    check("R9 no align", {31'b0, sp_align_fix}, 32'd0);
    // R7 thread requested, zero field -> fine
    run_p2(32'h0100_0200);
    check("R7 thread ok", {31'b0, p2_fault}, 32'd0);
    check("R9 align thread", {31'b0, sp_align_fix}, 32'd1);

    // R11 both strobes together
    @(negedge clk);
    ret_code = 32'hFFFF_FFF1; cur_exc = 9'd3; retire_st = 2'b10; restored_psr = '0;
    p1_start = 1'b1; p2_start = 1'b1;
    @(negedge clk);
    p1_start = 1'b0; p2_start = 1'b0;
    check("R11 p1 served", {31'b0, p1_valid}, 32'd1);
    check("R11 p2 ignored", {31'b0, p2_valid}, 32'd0);
    check("R11 no new_frame", {31'b0, new_frame}, 32'd0);

    // R10 reset clears a pending result
    @(negedge clk);
    p1_start = 1'b1; ret_code = 32'hFFFF_FFF5; rst = 1'b1;
    @(negedge clk);
    p1_start = 1'b0;
    check("R10 held in reset", {31'b0, p1_valid}, 32'd0);
    check("R10 no fault", {31'b0, p1_fault}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule